// File: doc/BRIEF.md
# Linked-List Command Chain Walker

This block follows a chain of command packets stored in a word-addressed RAM and streams their payload words, in order, to a downstream command consumer. A start pulse supplies a 24-bit byte pointer to the first node. Each node begins with a header word that carries two fields: a payload word count and the pointer to the next node. The payload words sit in the RAM words directly after the header. A zero-length node carries no payload, but the walker still follows its link.

A chain that links back into itself would otherwise never end. To guard against this, the walker marks every header it visits by setting one spare pointer bit in RAM. When a header whose link field already carries that bit is fetched, that node is the last one processed. A second pass then starts again from the start pointer, visits as many nodes as the first pass did, and clears the mark in each one. While walking, the block also adds up an estimated cost for the list, so the caller can charge the transfer time. The caller sees `done` and the final total once the cleanup pass has finished.

Top module: `chain_walker`

## Requirements
- R1: A header word holds the payload length in bits [31:24] and the next-node pointer in bits [23:0]. The walker presents each node's `length` payload words, read from the word indices that directly follow the header, on `pay_data_o` in order.
- R2: A pointer is masked to its low 21 bits, and bits [20:2] form the word index. Pointer bits [22:21] and [1:0] have no effect. Payload word indices wrap modulo 2^19.
- R3: A start pointer of 0xFFFFFF produces `done` with a total of 0, and the walker makes no RAM access and forwards no payload.
- R4: Each visited header is written back, on the cycle after its read and at the same index, with bit 23 set and every other bit unchanged.
- R5: The walk ends after the node whose fetched header has bit 23 set in its link field. This covers both the 0xFFFFFF end marker and a header already marked earlier in the same walk. A node that is reached again is therefore processed a second time.
- R6: After the walk, the walker re-follows the chain from the start pointer for exactly as many nodes as it visited. It writes each header back with bit 23 cleared, so a chain whose headers had bit 23 clear is restored exactly.
- R7: The cost total adds 10 for every visited node, plus 5 + length for every visited node whose length is nonzero.
- R8: A node of length 0 forwards no payload word, but its link is followed.
- R9: While `pay_valid_o` is high and `pay_ready_i` is low, `pay_valid_o` stays high and `pay_data_o` holds its value.
- R10: After reset, `busy_o`, `done_o`, `pay_valid_o` and `mem_en_o` are low. `done_o` is a one-cycle pulse with `cycles_o` valid. A start pulse while `busy_o` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| start_addr_i | input | 24 | Byte pointer to the first node |
| busy_o | output | 1 | Walk or cleanup in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cycles_o | output | 32 | Accumulated cost total |
| mem_en_o | output | 1 | RAM access enable |
| mem_we_o | output | 1 | RAM write (read when low) |
| mem_idx_o | output | 19 | RAM word index |
| mem_wdata_o | output | 32 | RAM write data |
| mem_rdata_i | input | 32 | RAM read data, one cycle after a read |
| pay_valid_o | output | 1 | Payload word valid |
| pay_ready_i | input | 1 | Downstream accepts payload |
| pay_data_o | output | 32 | Payload word |

## Verification
The assertions assume that the RAM returns read data exactly one cycle after a read request and that nothing else writes the RAM during a walk. The bench's RAM model meets both conditions by construction. The assertions also assume that `pay_ready_i` may change freely. The bench drives it either held high or randomly dropped each cycle. Random chains are placed in non-overlapping 16-word slots, with random high and low pointer bits that must be ignored. Each chain ends either at the end marker or by looping back to an earlier node, so every walk terminates.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int PTR_W  = 24;
  localparam int LEN_W  = 8;
  localparam int WORD_W = 32;
  localparam int MARK_BIT = PTR_W - 1;
  localparam logic [PTR_W-1:0] END_PTR = '1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR_RD,
    ST_HDR_WB,
    ST_PAY_RD,
    ST_PAY_LD,
    ST_PAY_TX,
    ST_LINK,
    ST_CLN_RD,
    ST_CLN_WB,
    ST_FIN
  } walk_state_e;
endpackage

// File: rtl/cw_cost_acc.sv
module cw_cost_acc #(
  parameter int COST_W    = 32,
  parameter int LEN_W     = 8,
  parameter int NODE_COST = 10,
  parameter int LOAD_COST = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [COST_W-1:0] total_o
);
  logic [COST_W-1:0] total_q, total_d, step;

  always_comb begin
    step = COST_W'(NODE_COST);
    if (len_i != '0) step = step + COST_W'(LOAD_COST) + COST_W'(len_i);
  end

  always_comb begin
    total_d = total_q;
    if (clr_i)      total_d = '0;
    else if (add_i) total_d = total_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) total_q <= '0;
    else        total_q <= total_d;
  end

  assign total_o = total_q;
endmodule

// File: rtl/cw_pay_stage.sv
module cw_pay_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic         vld_q, vld_d;
  logic [W-1:0] dat_q;

  always_comb begin
    vld_d = vld_q;
    if (load_i)                vld_d = 1'b1;
    else if (vld_q && ready_i) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (load_i) dat_q <= data_i;
    end
  end

  assign valid_o = vld_q;
  assign data_o  = dat_q;
endmodule

// File: rtl/chain_walker.sv
module chain_walker #(
  parameter int IDX_W  = 19,
  parameter int COST_W = 32,
  parameter int CNT_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [23:0]       start_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [COST_W-1:0] cycles_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [IDX_W-1:0]  mem_idx_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              pay_valid_o,
  input  logic              pay_ready_i,
  output logic [31:0]       pay_data_o
);
  import cw_pkg::*;

  localparam int WIN_W = IDX_W + 2;
  localparam logic [WORD_W-1:0] MARK_MASK = WORD_W'(1) << MARK_BIT;

  walk_state_e       state_q, state_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d, head_q, head_d, link_q, link_d;
  logic [LEN_W-1:0]  len_q, len_d, pcnt_q, pcnt_d;
  logic [IDX_W-1:0]  hidx_q, hidx_d;
  logic [CNT_W-1:0]  nvis_q, nvis_d, ccnt_q, ccnt_d;
  logic              pay_fire, cost_clr, cost_add, pay_load;
  logic [IDX_W-1:0]  ptr_idx;

  assign ptr_idx  = ptr_q[WIN_W-1:2];
  assign pay_fire = pay_valid_o && pay_ready_i;
  assign cost_clr = (state_q == ST_IDLE) && start_i;
  assign cost_add = (state_q == ST_HDR_WB);
  assign pay_load = (state_q == ST_PAY_LD);

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    head_d  = head_q;
    link_d  = link_q;
    len_d   = len_q;
    pcnt_d  = pcnt_q;
    hidx_d  = hidx_q;
    nvis_d  = nvis_q;
    ccnt_d  = ccnt_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        head_d  = start_addr_i;
        ptr_d   = start_addr_i;
        nvis_d  = '0;
        state_d = (start_addr_i == END_PTR) ? ST_FIN : ST_HDR_RD;
      end
      ST_HDR_RD: begin
        hidx_d  = ptr_idx;
        state_d = ST_HDR_WB;
      end
      ST_HDR_WB: begin
        len_d   = mem_rdata_i[31:24];
        link_d  = mem_rdata_i[PTR_W-1:0];
        nvis_d  = nvis_q + CNT_W'(1);
        pcnt_d  = '0;
        state_d = (mem_rdata_i[31:24] != '0) ? ST_PAY_RD : ST_LINK;
      end
      ST_PAY_RD: state_d = ST_PAY_LD;
      ST_PAY_LD: state_d = ST_PAY_TX;
      ST_PAY_TX: if (pay_fire) begin
        pcnt_d  = pcnt_q + LEN_W'(1);
        state_d = ((pcnt_q + LEN_W'(1)) == len_q) ? ST_LINK : ST_PAY_RD;
      end
      ST_LINK: begin
        if (link_q[MARK_BIT]) begin
          ptr_d   = head_q;
          ccnt_d  = '0;
          state_d = ST_CLN_RD;
        end else begin
          ptr_d   = link_q;
          state_d = ST_HDR_RD;
        end
      end
      ST_CLN_RD: begin
        hidx_d  = ptr_idx;
        state_d = ST_CLN_WB;
      end
      ST_CLN_WB: begin
        ptr_d   = PTR_W'(mem_rdata_i[WIN_W-1:0]);
        ccnt_d  = ccnt_q + CNT_W'(1);
        state_d = ((ccnt_q + CNT_W'(1)) == nvis_q) ? ST_FIN : ST_CLN_RD;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      head_q  <= '0;
      link_q  <= '0;
      len_q   <= '0;
      pcnt_q  <= '0;
      hidx_q  <= '0;
      nvis_q  <= '0;
      ccnt_q  <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      head_q  <= head_d;
      link_q  <= link_d;
      len_q   <= len_d;
      pcnt_q  <= pcnt_d;
      hidx_q  <= hidx_d;
      nvis_q  <= nvis_d;
      ccnt_q  <= ccnt_d;
    end
  end

  always_comb begin
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_idx_o   = hidx_q;
    mem_wdata_o = mem_rdata_i;
    unique case (state_q)
      ST_HDR_RD, ST_CLN_RD: begin
        mem_en_o  = 1'b1;
        mem_idx_o = ptr_idx;
      end
      ST_HDR_WB: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = mem_rdata_i | MARK_MASK;
      end
      ST_CLN_WB: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = mem_rdata_i & ~MARK_MASK;
      end
      ST_PAY_RD: begin
        mem_en_o  = 1'b1;
        mem_idx_o = hidx_q + IDX_W'(1) + IDX_W'(pcnt_q);
      end
      default: ;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_FIN);

  cw_cost_acc #(.COST_W(COST_W), .LEN_W(LEN_W)) u_cost (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (cost_clr),
    .add_i   (cost_add),
    .len_i   (mem_rdata_i[31:24]),
    .total_o (cycles_o)
  );

  cw_pay_stage #(.W(WORD_W)) u_pay (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (pay_load),
    .data_i  (mem_rdata_i),
    .ready_i (pay_ready_i),
    .valid_o (pay_valid_o),
    .data_o  (pay_data_o)
  );
endmodule

// File: rtl/cw_chk.sv
module cw_chk #(
  parameter int IDX_W = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             done_o,
  input logic             mem_en_o,
  input logic             mem_we_o,
  input logic [IDX_W-1:0] mem_idx_o,
  input logic [31:0]      mem_wdata_o,
  input logic [31:0]      mem_rdata_i,
  input logic             pay_valid_o,
  input logic             pay_ready_i,
  input logic [31:0]      pay_data_o
);
  localparam logic [31:0] KEEP = ~(32'h1 << 23);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid_o && !pay_ready_i) |=> (pay_valid_o && $stable(pay_data_o)));

  p_rmw_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> ($past(mem_en_o && !mem_we_o) && (mem_idx_o == $past(mem_idx_o))));

  p_wb_keeps_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> ((mem_wdata_o & KEEP) == (mem_rdata_i & KEEP)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_en_o && !pay_valid_o));

  p_done_drained_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!pay_valid_o && !mem_en_o));
endmodule

bind chain_walker cw_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_en_o    (mem_en_o),
  .mem_we_o    (mem_we_o),
  .mem_idx_o   (mem_idx_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdata_i (mem_rdata_i),
  .pay_valid_o (pay_valid_o),
  .pay_ready_i (pay_ready_i),
  .pay_data_o  (pay_data_o)
);

// File: tb/chain_walker_tb_top.sv
`timescale 1ns/1ps
module chain_walker_tb_top;
  localparam int IDX_W = 19;
  localparam int COST_W = 32;
  localparam logic [31:0] MARK = 32'h0080_0000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n, start_i, busy_o, done_o;
  logic [23:0]       start_addr_i;
  logic [COST_W-1:0] cycles_o;
  logic              mem_en_o, mem_we_o;
  logic [IDX_W-1:0]  mem_idx_o;
  logic [31:0]       mem_wdata_o, mem_rdata_i;
  logic              pay_valid_o, pay_ready_i;
  logic [31:0]       pay_data_o;

  chain_walker dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .busy_o(busy_o), .done_o(done_o), .cycles_o(cycles_o),
    .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_idx_o(mem_idx_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .pay_valid_o(pay_valid_o), .pay_ready_i(pay_ready_i), .pay_data_o(pay_data_o)
  );

  logic [31:0] ram [int unsigned];
  logic [31:0] mdl [int unsigned];
  logic [31:0] got_q [$];
  logic [31:0] exp_q [$];
  int unsigned exp_cost;
  int exp_n, tag_wr, clr_wr, acc_cnt;
  int vectors = 0, fails = 0;
  bit stall_mode = 0;
  bit hold_pend = 0;
  logic [31:0] hold_dat;

  always @(posedge clk) begin
    if (mem_en_o && !mem_we_o)
      mem_rdata_i <= ram.exists(int'(mem_idx_o)) ? ram[int'(mem_idx_o)] : 32'h0;
    if (mem_en_o && mem_we_o)
      ram[int'(mem_idx_o)] = mem_wdata_o;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  initial begin
    pay_ready_i = 1'b1;
    forever begin
      @(negedge clk);
      pay_ready_i = stall_mode ? (($urandom % 3) != 0) : 1'b1;
      #1;
      if (rst_n) begin
        if (mem_en_o) acc_cnt++;
        if (mem_en_o && mem_we_o) begin
          if (mem_wdata_o[23]) tag_wr++;
          else clr_wr++;
        end
        if (hold_pend)
          chk(pay_valid_o && pay_data_o == hold_dat, "R9 stall hold", {31'b0, pay_valid_o, pay_data_o}, {32'h1, hold_dat});
        if (pay_valid_o && pay_ready_i) got_q.push_back(pay_data_o);
        hold_pend = pay_valid_o && !pay_ready_i;
        hold_dat = pay_data_o;
      end
    end
  end

  function automatic logic [31:0] mrd(input int unsigned i);
    return mdl.exists(i) ? mdl[i] : 32'h0;
  endfunction

  task automatic model_walk(input logic [23:0] sa);
    logic [23:0] a;
    int unsigned idx;
    logic [31:0] h;
    int n;
    mdl = ram;
    exp_q.delete();
    exp_cost = 0;
    n = 0;
    if (sa != 24'hFFFFFF) begin
      a = sa;
      forever begin
        idx = int'(a[20:2]);
        h = mrd(idx);
        exp_cost += 10;
        if (h[31:24] != 0) exp_cost += 5 + int'(h[31:24]);
        mdl[idx] = h | MARK;
        for (int k = 0; k < int'(h[31:24]); k++)
          exp_q.push_back(mrd((idx + 1 + k) & 32'h7FFFF));
        n++;
        if (h[23]) break;
        a = h[23:0];
      end
      a = sa;
      for (int k = 0; k < n; k++) begin
        idx = int'(a[20:2]);
        h = mrd(idx) & ~MARK;
        mdl[idx] = h;
        a = {3'b0, h[20:0]};
      end
    end
    exp_n = n;
  endtask

  task automatic run_walk(input logic [23:0] sa, input bit poke, input string tag);
    int cyc;
    int bad;
    model_walk(sa);
    got_q.delete();
    tag_wr = 0; clr_wr = 0; acc_cnt = 0;
    @(negedge clk);
    start_i = 1'b1;
    start_addr_i = sa;
    @(negedge clk);
    start_i = 1'b0;
    start_addr_i = 24'h000040;
    cyc = 0;
    #2;
    while (!done_o && cyc < 20000) begin
      if (poke && cyc == 4) begin start_i = 1'b1; start_addr_i = 24'h000400; end
      else start_i = 1'b0;
      @(negedge clk);
      #2;
      cyc++;
    end
    start_i = 1'b0;
    chk(done_o, {"R10 done reached ", tag}, {63'b0, done_o}, 64'h1);
    chk(cycles_o == exp_cost, {"R7 cost ", tag}, cycles_o, exp_cost);
    chk(got_q.size() == exp_q.size(), {"R1 payload count ", tag}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], {"R1 payload word ", tag}, got_q[i], exp_q[i]);
    chk(tag_wr == exp_n, {"R4 mark writes ", tag}, tag_wr, exp_n);
    chk(clr_wr == exp_n, {"R6 clear writes ", tag}, clr_wr, exp_n);
    bad = 0;
    foreach (ram[k]) if (ram[k] !== mrd(k)) bad++;
    foreach (mdl[k]) if (!ram.exists(k) && mdl[k] != 0) bad++;
    chk(bad == 0, {"R6 memory image ", tag}, bad, 0);
    if (sa == 24'hFFFFFF)
      chk(acc_cnt == 0 && cycles_o == 0, "R3 end-marker start", acc_cnt, 0);
    @(negedge clk);
  endtask

  function automatic logic [23:0] ptr_of(input int unsigned idx);
    return {1'b0, 2'($urandom), idx[18:0], 2'($urandom)};
  endfunction

  task automatic build_random(output logic [23:0] sa);
    int nn, base;
    int unsigned hidx [8];
    int lens [8];
    logic [23:0] nx;
    ram.delete();
    nn = 1 + ($urandom % 8);
    base = $urandom % 32'h7FF00;
    for (int i = 0; i < nn; i++) begin
      hidx[i] = base + i * 16 + ($urandom % 8);
      lens[i] = $urandom % 7;
    end
    for (int i = 0; i < nn; i++) begin
      if (i + 1 < nn) nx = ptr_of(hidx[i+1]);
      else if (($urandom % 3) == 0) nx = ptr_of(hidx[$urandom % nn]);
      else nx = 24'hFFFFFF;
      ram[hidx[i]] = {8'(lens[i]), nx};
      for (int k = 0; k < lens[i]; k++) ram[hidx[i] + 1 + k] = $urandom;
    end
    sa = ptr_of(hidx[0]);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [23:0] sa;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; start_addr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R10 reset state
    chk(!busy_o && !done_o && !pay_valid_o && !mem_en_o, "R10 reset state",
        {busy_o, done_o, pay_valid_o, mem_en_o}, 0);

    // R3 end marker as start
    ram.delete();
    run_walk(24'hFFFFFF, 0, "endstart");

    // R1 R7 R8 three nodes, middle one empty
    ram.delete();
    ram[32'h10] = {8'd2, 24'h000080};
    ram[32'h11] = 32'hA0A0_0001; ram[32'h12] = 32'hA0A0_0002;
    ram[32'h20] = {8'd0, 24'h0000C0};
    ram[32'h30] = {8'd3, 24'hFFFFFF};
    ram[32'h31] = 32'hB1; ram[32'h32] = 32'hB2; ram[32'h33] = 32'hB3;
    run_walk(24'h000040, 0, "three");
    chk(cycles_o == 45, "R7 directed total", cycles_o, 45);

    // R5 loop back to first node
    ram.delete();
    ram[32'h100] = {8'd1, 24'h000800};
    ram[32'h101] = 32'hC0DE_0001;
    ram[32'h200] = {8'd2, 24'h000400};
    ram[32'h201] = 32'hC0DE_0002; ram[32'h202] = 32'hC0DE_0003;
    run_walk(24'h000400, 0, "loop");
    chk(got_q.size() == 4, "R5 revisit forwards again", got_q.size(), 4);
    chk(cycles_o == 49, "R5 loop total", cycles_o, 49);

    // R2 masked pointer bits and index wrap
    ram.delete();
    ram[32'h7FFFF] = {8'd2, 24'h600021};
    ram[32'h0] = 32'hD000_0000; ram[32'h1] = 32'hD000_0001;
    ram[32'h8] = {8'd1, 24'hFFFFFF};
    ram[32'h9] = 32'hD000_0009;
    run_walk(24'h5FFFFD, 1'b0, "wrap");
    chk(got_q.size() == 3 && got_q[0] == 32'hD000_0000, "R2 wrap order",
        got_q.size() > 0 ? got_q[0] : 32'h0, 32'hD000_0000);

    // R10 start while busy ignored
    ram.delete();
    ram[32'h10] = {8'd3, 24'hFFFFFF};
    ram[32'h11] = 32'h1; ram[32'h12] = 32'h2; ram[32'h13] = 32'h3;
    ram[32'h100] = {8'd5, 24'hFFFFFF};
    stall_mode = 1;
    run_walk(24'h000040, 1'b1, "R10 poke");
    stall_mode = 0;

    // random chains
    for (int t = 0; t < 30; t++) begin
      build_random(sa);
      stall_mode = t[0];
      run_walk(sa, t % 5 == 2, "random");
    end
    stall_mode = 0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule